// File: doc/BRIEF.md
# Glitch-Free Register-Selected Clock Source Multiplexer

This block drives one output clock from one of several input clocks. A 32-bit control word, written on a separate control clock, holds a selection field. A parameterised shift and mask locate that field. A parameterised encoding turns the field value into a source index. The encoding can be zero-based, offset by one, one-hot, or taken from a per-source code table. The same encoding is used in reverse to rebuild the read-back word.

Parameters can make the selection read-only. They can also enable a guarded-write form, in which only the low half of the word carries data and the high half says which low bits a write may touch.

Every switch is break-before-make. The old source stops on its own falling edge. The new source starts only after the stop has been seen in the new source's domain, and it also starts on a falling edge, so no short pulse reaches the output. A status output on the control clock reports which source is really driving the output.

Top module: `clk_src_mux`

## Requirements
- R1: While `rst` is high, `rd_data` reads 0 and `active_sel` reads 0. After reset, source 0 is selected: `active_sel` settles to 0, `clk_out` follows `src_clk[0]`, and `rd_data` shows the code of source 0.
- R2: In zero-based mode, the field is `(word >> FIELD_SHIFT) & FIELD_MASK`, and a field value k below `NUM_SRC` selects source k. Bits outside the field have no effect. Read-back is `k << FIELD_SHIFT`.
- R3: In offset-by-one mode, a field value k+1 selects source k. Read-back is `(k+1) << FIELD_SHIFT`.
- R4: In one-hot mode, a field with only bit k set selects source k. Read-back is `(1<<k) << FIELD_SHIFT`.
- R5: In table mode, a field equal to `CODE_TABLE[k] & FIELD_MASK` selects source k. Read-back is that code shifted by `FIELD_SHIFT`.
- R6: In guarded-write mode, bit i+16 of a written word allows low bit i to change. The new low half is `(readback & ~wr[31:16]) | (wr[15:0] & wr[31:16])`. A write whose high half is zero changes nothing.
- R7: In read-only mode, no write changes the selection, the read-back, or the output source.
- R8: A field value that decodes to no source leaves the selection unchanged. Examples are zero in offset-by-one mode, an out-of-range index, a one-hot value with more or fewer than one bit set, and a code that is not in the table.
- R9: At most one source is gated onto the output at any time. No high or low phase of `clk_out` is shorter than the shortest half-period among the sources.
- R10: `active_sel` takes the new index only once that source is already driving `clk_out`. It does not change in the first two control cycles after a write. Once it reads k, `clk_out` equals `src_clk[k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock for the register port and status |
| rst | input | 1 | Synchronous active-high reset, control domain |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word written on `wr_en` |
| rd_data | output | 32 | Registered read-back of the requested selection |
| src_clk | input | NUM_SRC | Candidate source clocks |
| src_rst | input | NUM_SRC | Synchronous active-high reset, one per source domain |
| clk_out | output | 1 | Selected, gated output clock |
| active_sel | output | IDX_W | Index of the source currently driving `clk_out` |

## Verification
The assertions assume that every source clock keeps running while a switch is under way. They also assume that a new selection is written only after the previous switch has completed. If two switches overlapped, the handshakes of two sources could both be in flight at once, and the exclusion check and the status check would then not hold. The stimulus leaves 80 control cycles between writes, which is several times the slowest worst-case handover. It also releases all resets together while every source is toggling.

// File: rtl/ckmux_pkg.sv
`timescale 1ns/1ps
package ckmux_pkg;
  typedef enum logic [1:0] {
    ENC_ZERO   = 2'd0,
    ENC_ONE    = 2'd1,
    ENC_ONEHOT = 2'd2,
    ENC_TABLE  = 2'd3
  } enc_e;
endpackage

// File: rtl/ckmux_codec.sv
`timescale 1ns/1ps
module ckmux_codec #(
  parameter int NUM_SRC = 4,
  parameter int IDX_W = 2,
  parameter int FIELD_SHIFT = 0,
  parameter logic [31:0] FIELD_MASK = 32'h3,
  parameter ckmux_pkg::enc_e ENC = ckmux_pkg::ENC_ZERO,
  parameter logic [NUM_SRC-1:0][31:0] CODE_TABLE = '0
) (
  input  logic [31:0]      word_in,
  input  logic [IDX_W-1:0] cur_idx,
  output logic [IDX_W-1:0] dec_idx,
  output logic             dec_ok,
  output logic [31:0]      cur_img
);
  function automatic logic [31:0] code_of(input int k);
    case (ENC)
      ckmux_pkg::ENC_ONE:    code_of = 32'(k + 1);
      ckmux_pkg::ENC_ONEHOT: code_of = 32'd1 << k;
      ckmux_pkg::ENC_TABLE:  code_of = CODE_TABLE[k];
      default:               code_of = 32'(k);
    endcase
  endfunction

  logic [31:0] field;

  always_comb begin
    field   = (word_in >> FIELD_SHIFT) & FIELD_MASK;
    dec_ok  = 1'b0;
    dec_idx = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (!dec_ok && field == (code_of(k) & FIELD_MASK)) begin
        dec_ok  = 1'b1;
        dec_idx = IDX_W'(k);
      end
    end
    cur_img = (code_of(int'(cur_idx)) & FIELD_MASK) << FIELD_SHIFT;
  end
endmodule

// File: rtl/ckmux_gate_cell.sv
`timescale 1ns/1ps
module ckmux_gate_cell #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_src,
  input  logic rst_src,
  input  logic req,
  output logic busy,
  output logic gate
);
  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk_src) begin
    if (rst_src) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], req};
  end

  // enable changes only while this source is low
  always_ff @(negedge clk_src) begin
    if (rst_src) gate <= 1'b0;
    else         gate <= sync_q[SYNC_STAGES-1];
  end

  assign busy = gate | (|sync_q);
endmodule

// File: rtl/ckmux_status.sv
`timescale 1ns/1ps
module ckmux_status #(
  parameter int NUM_SRC = 4,
  parameter int IDX_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] gate_async,
  output logic [IDX_W-1:0]   active_sel
);
  logic [NUM_SRC-1:0] s1_q, s2_q;
  logic [IDX_W-1:0]   hot_idx;
  logic               one_hot;

  always_comb begin
    hot_idx = '0;
    for (int k = 0; k < NUM_SRC; k++)
      if (s2_q[k]) hot_idx = IDX_W'(k);
    one_hot = ($countones(s2_q) == 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q       <= '0;
      s2_q       <= '0;
      active_sel <= '0;
    end else begin
      s1_q <= gate_async;
      s2_q <= s1_q;
      if (one_hot) active_sel <= hot_idx;
    end
  end
endmodule

// File: rtl/clk_src_mux.sv
`timescale 1ns/1ps
module clk_src_mux #(
  parameter int NUM_SRC = 4,
  parameter int IDX_W = $clog2(NUM_SRC),
  parameter int FIELD_SHIFT = 0,
  parameter logic [31:0] FIELD_MASK = 32'h3,
  parameter ckmux_pkg::enc_e ENC = ckmux_pkg::ENC_ZERO,
  parameter logic [NUM_SRC-1:0][31:0] CODE_TABLE = '0,
  parameter bit READ_ONLY = 1'b0,
  parameter bit HW_MASK = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [31:0]        wr_data,
  output logic [31:0]        rd_data,
  input  logic [NUM_SRC-1:0] src_clk,
  input  logic [NUM_SRC-1:0] src_rst,
  output logic               clk_out,
  output logic [IDX_W-1:0]   active_sel
);
  logic [IDX_W-1:0]   sel_req;
  logic [IDX_W-1:0]   dec_idx;
  logic               dec_ok;
  logic [31:0]        cur_img;
  logic [31:0]        word_in;
  logic [NUM_SRC-1:0] req, busy, gate;

  generate
    if (HW_MASK) begin : g_hw
      assign word_in = {16'h0000,
                        (cur_img[15:0] & ~wr_data[31:16]) |
                        (wr_data[15:0] & wr_data[31:16])};
    end else begin : g_plain
      assign word_in = wr_data;
    end
  endgenerate

  ckmux_codec #(
    .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .FIELD_SHIFT(FIELD_SHIFT),
    .FIELD_MASK(FIELD_MASK), .ENC(ENC), .CODE_TABLE(CODE_TABLE)
  ) codec_i (
    .word_in(word_in), .cur_idx(sel_req),
    .dec_idx(dec_idx), .dec_ok(dec_ok), .cur_img(cur_img)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_req <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en && !READ_ONLY && dec_ok) sel_req <= dec_idx;
      rd_data <= cur_img;
    end
  end

  // a source may start only when every other source is idle
  always_comb begin
    for (int k = 0; k < NUM_SRC; k++)
      req[k] = (sel_req == IDX_W'(k)) &&
               !(|(busy & ~(NUM_SRC'(1) << k)));
  end

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      ckmux_gate_cell #(.SYNC_STAGES(SYNC_STAGES)) cell_i (
        .clk_src(src_clk[g]), .rst_src(src_rst[g]),
        .req(req[g]), .busy(busy[g]), .gate(gate[g])
      );
    end
  endgenerate

  assign clk_out = |(src_clk & gate);

  ckmux_status #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) status_i (
    .clk(clk), .rst(rst), .gate_async(gate), .active_sel(active_sel)
  );

  p_mutex_gates_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gate));

  p_bad_code_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !dec_ok) |=> (sel_req == $past(sel_req)));

  p_active_driving_r10: assert property (@(posedge clk) disable iff (rst)
    (active_sel != $past(active_sel)) |-> gate[active_sel]);

  generate
    if (READ_ONLY) begin : g_ro_chk
      p_ro_hold_r7: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> $stable(sel_req));
    end
    if (HW_MASK) begin : g_hw_chk
      p_unflagged_write_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[31:16] == 16'h0000) |=> $stable(sel_req));
    end
  endgenerate
endmodule

// File: tb/clk_src_mux_tb_top.sv
`timescale 1ns/1ps
module clk_src_mux_tb_top;
  localparam int ND = 5;
  localparam int NS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NS-1:0] src_clk = '0;
  logic [NS-1:0] src_rst = '1;
  logic [ND-1:0] wr_en = '0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   drd [ND];
  logic [1:0]    dact [ND];
  logic [ND-1:0] dout;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;
  initial begin #0.5; forever #5  src_clk[0] = ~src_clk[0]; end
  initial begin #0.5; forever #7  src_clk[1] = ~src_clk[1]; end
  initial begin #0.5; forever #3  src_clk[2] = ~src_clk[2]; end
  initial begin #0.5; forever #11 src_clk[3] = ~src_clk[3]; end

  clk_src_mux #(.NUM_SRC(NS), .FIELD_SHIFT(4), .FIELD_MASK(32'h7),
    .ENC(ckmux_pkg::ENC_ZERO)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en[0]), .wr_data(wr_data), .rd_data(drd[0]),
    .src_clk(src_clk), .src_rst(src_rst), .clk_out(dout[0]), .active_sel(dact[0]));

  clk_src_mux #(.NUM_SRC(NS), .FIELD_SHIFT(2), .FIELD_MASK(32'h7),
    .ENC(ckmux_pkg::ENC_ONE)) dut_one_i (
    .clk(clk), .rst(rst), .wr_en(wr_en[1]), .wr_data(wr_data), .rd_data(drd[1]),
    .src_clk(src_clk), .src_rst(src_rst), .clk_out(dout[1]), .active_sel(dact[1]));

  clk_src_mux #(.NUM_SRC(NS), .FIELD_SHIFT(0), .FIELD_MASK(32'hF),
    .ENC(ckmux_pkg::ENC_ONEHOT)) dut_hot_i (
    .clk(clk), .rst(rst), .wr_en(wr_en[2]), .wr_data(wr_data), .rd_data(drd[2]),
    .src_clk(src_clk), .src_rst(src_rst), .clk_out(dout[2]), .active_sel(dact[2]));

  clk_src_mux #(.NUM_SRC(NS), .FIELD_SHIFT(8), .FIELD_MASK(32'hF),
    .ENC(ckmux_pkg::ENC_TABLE), .HW_MASK(1'b1),
    .CODE_TABLE({32'h3, 32'hC, 32'h9, 32'h5})) dut_tab_i (
    .clk(clk), .rst(rst), .wr_en(wr_en[3]), .wr_data(wr_data), .rd_data(drd[3]),
    .src_clk(src_clk), .src_rst(src_rst), .clk_out(dout[3]), .active_sel(dact[3]));

  clk_src_mux #(.NUM_SRC(NS), .FIELD_SHIFT(0), .FIELD_MASK(32'h3),
    .ENC(ckmux_pkg::ENC_ZERO), .READ_ONLY(1'b1)) dut_ro_i (
    .clk(clk), .rst(rst), .wr_en(wr_en[4]), .wr_data(wr_data), .rd_data(drd[4]),
    .src_clk(src_clk), .src_rst(src_rst), .clk_out(dout[4]), .active_sel(dact[4]));

  // pulse-width monitor on the zero-based instance output
  realtime last_t = 0.0;
  realtime min_hi = 1.0e9;
  realtime min_lo = 1.0e9;
  bit seen_edge = 0;
  int n_edges = 0;
  always @(dout[0]) begin
    if (seen_edge) begin
      if (dout[0]) min_lo = ($realtime - last_t < min_lo) ? $realtime - last_t : min_lo;
      else         min_hi = ($realtime - last_t < min_hi) ? $realtime - last_t : min_hi;
    end
    seen_edge = 1;
    last_t = $realtime;
    n_edges++;
  end

  typedef struct packed {
    logic [31:0] wd;
    logic [1:0]  exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'h0000_0030, 2'd3},
    '{32'h0000_0010, 2'd1},
    '{32'h0000_0050, 2'd1},
    '{32'h0000_0020, 2'd2},
    '{32'h0000_0000, 2'd0},
    '{32'h0000_0070, 2'd0},
    '{32'hFFFF_FF1F, 2'd1},
    '{32'h0000_0030, 2'd3}
  };

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_write(input int d, input logic [31:0] v);
    @(negedge clk);
    wr_data = v;
    wr_en[d] = 1'b1;
    @(negedge clk);
    wr_en[d] = 1'b0;
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic verify(input int d, input logic [1:0] exp,
                        input logic [31:0] exp_rd, input string req);
    int bad;
    bad = 0;
    wait_cyc(80);
    check(req, "active_sel", 32'(dact[d]), 32'(exp));
    check(req, "rd_data", drd[d], exp_rd);
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (dout[d] !== src_clk[exp]) bad++;
    end
    check("R10", "clk_out mismatches vs selected source", 32'(bad), 32'd0);
  endtask

  initial begin
    src_rst = '1;
    rst = 1'b1;
    wait_cyc(4);
    for (int d = 0; d < ND; d++) begin
      check("R1", "rd_data in reset", drd[d], 32'h0);
      check("R1", "active_sel in reset", 32'(dact[d]), 32'h0);
    end
    rst = 1'b0;
    src_rst = '0;
    verify(0, 2'd0, 32'h0,   "R1");
    verify(1, 2'd0, 32'h4,   "R1");
    verify(2, 2'd0, 32'h1,   "R1");
    verify(3, 2'd0, 32'h500, "R1");
    verify(4, 2'd0, 32'h0,   "R1");

    // R2 / R8 table walk on the zero-based instance
    for (int i = 0; i < 8; i++) begin
      do_write(0, VECS[i].wd);
      verify(0, VECS[i].exp, 32'(VECS[i].exp) << 4, "R2");
    end

    // R10: status must hold its old value right after a write
    do_write(0, 32'h0000_0020);
    wait_cyc(1);
    check("R10", "active_sel early", 32'(dact[0]), 32'd3);
    verify(0, 2'd2, 32'h20, "R10");

    // R3 offset-by-one
    do_write(1, 32'd3 << 2);  verify(1, 2'd2, 32'hC,  "R3");
    do_write(1, 32'd0);       verify(1, 2'd2, 32'hC,  "R8");
    do_write(1, 32'd5 << 2);  verify(1, 2'd2, 32'hC,  "R8");
    do_write(1, 32'd4 << 2);  verify(1, 2'd3, 32'h10, "R3");

    // R4 one-hot
    do_write(2, 32'b0100);    verify(2, 2'd2, 32'h4, "R4");
    do_write(2, 32'b0110);    verify(2, 2'd2, 32'h4, "R8");
    do_write(2, 32'b0000);    verify(2, 2'd2, 32'h4, "R8");
    do_write(2, 32'b1000);    verify(2, 2'd3, 32'h8, "R4");

    // R5 table with R6 guarded writes
    do_write(3, 32'h0F00_0C00); verify(3, 2'd2, 32'hC00, "R5");
    do_write(3, 32'h0000_0900); verify(3, 2'd2, 32'hC00, "R6");
    do_write(3, 32'h0F00_0700); verify(3, 2'd2, 32'hC00, "R8");
    do_write(3, 32'h0F00_0300); verify(3, 2'd3, 32'h300, "R5");
    do_write(3, 32'h0700_0500); verify(3, 2'd0, 32'h500, "R6");

    // R7 read-only
    do_write(4, 32'd2);       verify(4, 2'd0, 32'h0, "R7");
    do_write(4, 32'd3);       verify(4, 2'd0, 32'h0, "R7");

    // R9 pulse widths on the switched output
    checks++;
    if (min_hi < 2.9 || min_lo < 2.9 || n_edges < 100) begin
      failures++;
      $display("FAIL R9 min_high=%0t min_low=%0t edges=%0d expected>=3ns", min_hi, min_lo, n_edges);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule